// File: doc/BRIEF.md
# Translation Fault Status Register

This block holds the 32-bit status word of an address-translation fault reporting unit. Detection logic elsewhere sends one-cycle strobes when something goes wrong: a device-side translation cache invalidation times out, an invalidation completion arrives with a bad tag or source, the invalidation queue yields a bad or unfetchable descriptor, or the fault log receives its record at index 0. Each strobe latches a sticky flag. Software reads the word through a simple register port and clears flags by writing ones to them.

The fault recording logic also drives a primary pending-fault flag with a set strobe and a clear strobe. The set strobe carries a record index. When the flag goes from clear to set, the index of the first pending record is captured. The flag itself cannot be changed by software.

Whenever any flag goes from 0 to 1, the block can raise a single-cycle fault-event request. An enable input, supplied by the separate event control logic, gates this request.

Top module: `fault_status_unit`

## Requirements
- R1: After a synchronous reset the register reads 0x00000000 and `evt_req` is 0.
- R2: Bits 31:16, 7, 2 and 0 always read 0. A read at any address other than offset 0x034 returns 0. A write to any other address changes nothing.
- R3: The strobes `inv_timeout`, `inv_cpl_err` and `inv_queue_err` set bits 6, 5 and 4 respectively, one clock after the strobe. These bits stay set until software clears them.
- R4: At offset 0x034, writing 1 to any of bits 6..3 clears that bit. Writing 0 to a bit leaves it unchanged.
- R5: If a strobe and a software clear hit the same bit among 6..4 in the same cycle, the bit ends up set.
- R6: Bit 3 sets on `rec0_written` only if it is currently 0. If bit 3 is already 1 and a software clear coincides with `rec0_written`, bit 3 becomes 0.
- R7: Bit 1 sets on `pend_set` and clears on `pend_clear`; if both arrive together, `pend_set` wins. Software writes have no effect on bit 1.
- R8: Bits 15:8 capture `pend_idx` in the cycle where bit 1 goes from 0 to 1. A later `pend_set` while bit 1 is already set does not change them. These bits read 0 while bit 1 is 0.
- R9: `evt_req` pulses high for exactly one cycle, in the same clock as the update. It does so when any of bits 1, 3, 4, 5 or 6 goes from 0 to 1 and `evt_en` was 1 in the cycle of the cause. Several bits rising together produce a single pulse.
- R10: `evt_req` stays 0 in two cases: when `evt_en` was 0, and when the strobed bit was already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | 32 | Write data (ones clear sticky bits) |
| rd_addr | input | 12 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| inv_timeout | input | 1 | Invalidation completion time-out strobe |
| inv_cpl_err | input | 1 | Invalid invalidation completion strobe |
| inv_queue_err | input | 1 | Invalidation queue error strobe |
| rec0_written | input | 1 | Fault record 0 written strobe |
| pend_set | input | 1 | Primary pending fault set strobe |
| pend_clear | input | 1 | Primary pending fault clear strobe |
| pend_idx | input | 8 | Record index accompanying pend_set |
| evt_en | input | 1 | Fault event enable |
| evt_req | output | 1 | Fault event request pulse |

## Verification
Each strobe is first tried alone from a clear state, which shows the set path and the event pulse separately for each bit. Strobes are then paired with software clears of the same bit, both when that bit is clear and when it is already set; this separates set-wins from the only-when-clear rule on bit 3. Repeated pending sets with differing indices, followed by a clear and then a combined set and clear, show that the index is captured only on the first set and hidden while the flag is off. A long stretch of random strobes, writes and enable toggling is compared every cycle against a behavioural model, which catches wrong priorities and missing or extra event pulses.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FSR_WORD_W   = 32;
    localparam int FSR_IDX_W    = 8;
    localparam int FSR_IDX_LSB  = 8;
    localparam int FSR_STICKY_N = 4;   // bit 3 (first-record flag) .. bit 6 (time-out)
    localparam int FSR_STICKY_LSB = 3;
    localparam int FSR_PPF_POS  = 1;

    typedef struct packed {
        logic [FSR_IDX_W-1:0]    idx;
        logic [FSR_STICKY_N-1:0] sticky;  // [0]=rec0 flag, [1]=queue, [2]=completion, [3]=time-out
        logic                    ppf;
    } fsr_state_t;

    function automatic logic [FSR_WORD_W-1:0] fsr_pack(input fsr_state_t s);
        logic [FSR_WORD_W-1:0] w;
        w = '0;
        w[FSR_PPF_POS] = s.ppf;
        w[FSR_STICKY_LSB +: FSR_STICKY_N] = s.sticky;
        w[FSR_IDX_LSB +: FSR_IDX_W] = s.ppf ? s.idx : '0;
        return w;
    endfunction
endpackage

// File: rtl/fsr_sticky_bit.sv
module fsr_sticky_bit #(
    parameter bit SET_ONLY_WHEN_CLEAR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o,
    output logic rise_o
);
    logic set_eff;
    logic q_nxt;

    generate
        if (SET_ONLY_WHEN_CLEAR) begin : g_gated
            assign set_eff = set_i & ~q_o;
        end else begin : g_plain
            assign set_eff = set_i;
        end
    endgenerate

    always_comb begin
        if (set_eff)      q_nxt = 1'b1;
        else if (clr_i)   q_nxt = 1'b0;
        else              q_nxt = q_o;
    end

    assign rise_o = q_nxt & ~q_o;

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= q_nxt;
    end
endmodule

// File: rtl/fsr_pend_capture.sv
module fsr_pend_capture #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             flag_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             rise_o
);
    logic first_set;

    assign first_set = set_i & ~flag_o;
    assign rise_o    = first_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            idx_o  <= '0;
        end else begin
            if (set_i)       flag_o <= 1'b1;
            else if (clr_i)  flag_o <= 1'b0;
            if (first_set)   idx_o  <= idx_i;
        end
    end
endmodule

// File: rtl/fsr_event_gen.sv
module fsr_event_gen #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [N-1:0] rise_i,
    output logic         req_o
);
    always_ff @(posedge clk) begin
        if (rst) req_o <= 1'b0;
        else     req_o <= en_i & (|rise_i);
    end
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h034
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [FSR_WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [FSR_WORD_W-1:0] rd_data,
    input  logic                  inv_timeout,
    input  logic                  inv_cpl_err,
    input  logic                  inv_queue_err,
    input  logic                  rec0_written,
    input  logic                  pend_set,
    input  logic                  pend_clear,
    input  logic [FSR_IDX_W-1:0]  pend_idx,
    input  logic                  evt_en,
    output logic                  evt_req
);
    localparam int EVT_N = FSR_STICKY_N + 1;

    fsr_state_t              state;
    logic                    wr_hit;
    logic [FSR_STICKY_N-1:0] sticky_set;
    logic [FSR_STICKY_N-1:0] sticky_clr;
    logic [FSR_STICKY_N-1:0] sticky_rise;
    logic                    ppf_rise;
    logic [FSR_WORD_W-1:0]   status_word;

    assign wr_hit     = wr_en && (wr_addr == REG_OFFSET);
    assign sticky_set = {inv_timeout, inv_cpl_err, inv_queue_err, rec0_written};

    genvar gi;
    generate
        for (gi = 0; gi < FSR_STICKY_N; gi++) begin : g_sticky
            assign sticky_clr[gi] = wr_hit & wr_data[FSR_STICKY_LSB + gi];
            fsr_sticky_bit #(
                .SET_ONLY_WHEN_CLEAR(gi == 0)
            ) bit_i (
                .clk    (clk),
                .rst    (rst),
                .set_i  (sticky_set[gi]),
                .clr_i  (sticky_clr[gi]),
                .q_o    (state.sticky[gi]),
                .rise_o (sticky_rise[gi])
            );
        end
    endgenerate

    fsr_pend_capture #(
        .IDX_W(FSR_IDX_W)
    ) pend_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (pend_set),
        .clr_i  (pend_clear),
        .idx_i  (pend_idx),
        .flag_o (state.ppf),
        .idx_o  (state.idx),
        .rise_o (ppf_rise)
    );

    fsr_event_gen #(
        .N(EVT_N)
    ) evt_i (
        .clk    (clk),
        .rst    (rst),
        .en_i   (evt_en),
        .rise_i ({sticky_rise, ppf_rise}),
        .req_o  (evt_req)
    );

    assign status_word = fsr_pack(state);
    assign rd_data     = (rd_addr == REG_OFFSET) ? status_word : '0;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] status_word,
    input logic        inv_timeout,
    input logic        inv_queue_err,
    input logic        pend_set,
    input logic        pend_clear,
    input logic        evt_en,
    input logic        evt_req
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (status_word[31:16] == 16'h0) && !status_word[7] && !status_word[2] && !status_word[0]);

    assert_timeout_sets_R3: assert property (@(posedge clk) disable iff (rst)
        inv_timeout |=> status_word[6]);

    assert_queue_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        inv_queue_err |=> status_word[4]);

    assert_pend_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!pend_set && !pend_clear) |=> $stable(status_word[1]));

    assert_idx_hidden_R8: assert property (@(posedge clk) disable iff (rst)
        !status_word[1] |-> (status_word[15:8] == 8'h00));

    assert_idx_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (status_word[1] && (pend_set || !pend_clear)) |=> $stable(status_word[15:8]));

    assert_evt_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        evt_req |-> ((|(status_word[6:3] & ~$past(status_word[6:3]))) ||
                     (status_word[1] && !$past(status_word[1]))));

    assert_evt_gated_R10: assert property (@(posedge clk) disable iff (rst)
        !evt_en |=> !evt_req);
endmodule

bind fault_status_unit fsr_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .status_word   (status_word),
    .inv_timeout   (inv_timeout),
    .inv_queue_err (inv_queue_err),
    .pend_set      (pend_set),
    .pend_clear    (pend_clear),
    .evt_en        (evt_en),
    .evt_req       (evt_req)
);

// File: tb/fault_status_unit_tb_top.sv
module fault_status_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] OFF = 12'h034;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = OFF;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = OFF;
    logic [31:0] rd_data;
    logic        inv_timeout = 1'b0, inv_cpl_err = 1'b0, inv_queue_err = 1'b0;
    logic        rec0_written = 1'b0, pend_set = 1'b0, pend_clear = 1'b0;
    logic [7:0]  pend_idx = '0;
    logic        evt_en = 1'b0;
    logic        evt_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_ite, m_ice, m_iqe, m_apf, m_ppf, m_evt;
    int m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .inv_timeout(inv_timeout), .inv_cpl_err(inv_cpl_err), .inv_queue_err(inv_queue_err),
        .rec0_written(rec0_written), .pend_set(pend_set), .pend_clear(pend_clear),
        .pend_idx(pend_idx), .evt_en(evt_en), .evt_req(evt_req)
    );

    always @(posedge clk) begin
        bit w, n_ite, n_ice, n_iqe, n_apf, n_ppf;
        if (rst) begin
            m_ite = 0; m_ice = 0; m_iqe = 0; m_apf = 0; m_ppf = 0; m_evt = 0; m_idx = 0;
        end else begin
            w = wr_en && (wr_addr == OFF);
            n_ite = inv_timeout   ? 1 : (w && wr_data[6]) ? 0 : m_ite;
            n_ice = inv_cpl_err   ? 1 : (w && wr_data[5]) ? 0 : m_ice;
            n_iqe = inv_queue_err ? 1 : (w && wr_data[4]) ? 0 : m_iqe;
            n_apf = (rec0_written && !m_apf) ? 1 : (w && wr_data[3]) ? 0 : m_apf;
            n_ppf = pend_set ? 1 : pend_clear ? 0 : m_ppf;
            if (pend_set && !m_ppf) m_idx = int'(pend_idx);
            m_evt = evt_en && ((n_ite && !m_ite) || (n_ice && !m_ice) || (n_iqe && !m_iqe) ||
                               (n_apf && !m_apf) || (n_ppf && !m_ppf));
            m_ite = n_ite; m_ice = n_ice; m_iqe = n_iqe; m_apf = n_apf; m_ppf = n_ppf;
        end
    end

    function automatic logic [31:0] model_word(input logic [11:0] a);
        logic [31:0] v;
        v = '0;
        if (a == OFF) begin
            v[6] = m_ite; v[5] = m_ice; v[4] = m_iqe; v[3] = m_apf; v[1] = m_ppf;
            if (m_ppf) v[15:8] = m_idx[7:0];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_data = '0; wr_addr = OFF;
        inv_timeout = 0; inv_cpl_err = 0; inv_queue_err = 0;
        rec0_written = 0; pend_set = 0; pend_clear = 0; pend_idx = '0;
    endtask

    // one clock; compare against the model away from the edge, then release strobes
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R3 model word", rd_data, model_word(rd_addr));
        chk("R9 model event", {31'b0, evt_req}, {31'b0, m_evt});
        idle_inputs();
    endtask

    task automatic sw_write(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset event", {31'b0, evt_req}, 32'h0);
        rst = 0;
        evt_en = 1;

        inv_timeout = 1; cyc();
        chk("R3 time-out sets bit 6", rd_data, 32'h40);
        chk("R9 pulse on rise", {31'b0, evt_req}, 32'h1);
        cyc();
        chk("R3 bit 6 sticky", rd_data, 32'h40);
        chk("R9 pulse lasts one cycle", {31'b0, evt_req}, 32'h0);

        sw_write(OFF, 32'h0); cyc();
        chk("R4 writing zero keeps bit", rd_data, 32'h40);
        sw_write(OFF, 32'h40); cyc();
        chk("R4 writing one clears", rd_data, 32'h0);

        inv_queue_err = 1; sw_write(OFF, 32'h10); cyc();
        chk("R5 set beats clear", rd_data, 32'h10);
        inv_queue_err = 1; sw_write(OFF, 32'h10); cyc();
        chk("R5 set beats clear when set", rd_data, 32'h10);
        chk("R10 no pulse when already set", {31'b0, evt_req}, 32'h0);

        rec0_written = 1; cyc();
        chk("R6 rec0 sets bit 3", rd_data, 32'h18);
        chk("R9 pulse for bit 3", {31'b0, evt_req}, 32'h1);
        rec0_written = 1; sw_write(OFF, 32'h08); cyc();
        chk("R6 clear wins while bit 3 set", rd_data, 32'h10);

        sw_write(OFF, 32'hFFFF0086); cyc();
        chk("R2 R7 reserved and bit 1 writes ignored", rd_data, 32'h10);

        pend_set = 1; pend_idx = 8'hA5; cyc();
        chk("R8 index captured", rd_data, 32'hA512);
        chk("R7 pulse for bit 1", {31'b0, evt_req}, 32'h1);
        pend_set = 1; pend_idx = 8'h3C; cyc();
        chk("R8 index kept on second set", rd_data, 32'hA512);
        pend_clear = 1; cyc();
        chk("R8 index hidden when clear", rd_data, 32'h10);
        pend_set = 1; pend_clear = 1; pend_idx = 8'h07; cyc();
        chk("R7 set beats clear", rd_data, 32'h0712);

        evt_en = 0; inv_cpl_err = 1; cyc();
        chk("R10 disabled event", {31'b0, evt_req}, 32'h0);
        chk("R3 bit 5 sets", rd_data, 32'h0732);

        rd_addr = 12'h038; sw_write(12'h038, 32'hFFFFFFFF); cyc();
        chk("R2 other address reads zero", rd_data, 32'h0);
        rd_addr = OFF; @(negedge clk);
        chk("R2 other address write ignored", rd_data, 32'h0732);

        evt_en = 1; sw_write(OFF, 32'h78); pend_clear = 1; cyc();
        chk("R4 clear all", rd_data, 32'h0);
        inv_timeout = 1; inv_cpl_err = 1; inv_queue_err = 1; cyc();
        chk("R9 joint rise word", rd_data, 32'h70);
        chk("R9 joint rise one pulse", {31'b0, evt_req}, 32'h1);
        cyc();
        chk("R9 joint pulse ends", {31'b0, evt_req}, 32'h0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            inv_timeout   = (r[2:0] == 0);
            inv_cpl_err   = (r[5:3] == 0);
            inv_queue_err = (r[8:6] == 0);
            rec0_written  = (r[11:9] == 0);
            pend_set      = (r[14:12] == 0);
            pend_clear    = (r[17:15] == 0);
            pend_idx      = r[31:24];
            evt_en        = r[18] | r[19];
            if (r[22:20] < 3) sw_write((r[23] ? OFF : 12'h030), {$urandom} & 32'hFFFF_FFFF);
            rd_addr = r[21] && r[22] ? 12'h000 : OFF;
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule